// File: doc/BRIEF.md
# Stereo Soft Mute Controller

This block sits in a stereo PCM datapath and silences the stream in one of two ways. For converted data, a mute request drives a gain coefficient down by one step per stereo frame until the output is silent. Releasing the request drives the gain back up to unity at the same rate. The full ramp takes 1024 frames. For pass-through data, the samples are not scaled. They are switched between zero and their true value, and the switch takes effect only at a rising edge of the left/right clock. A loss-of-lock input from the clock generator has the same effect as a mute request.

One beat on the input stream carries one stereo frame (a left and a right sample). The input and output streams use valid/ready handshakes. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. The block has one output register. `in_ready` is high when that register is empty or when the downstream side is taking its contents in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new beat is accepted. The control inputs `mute`, `unlock`, `pass_thru` and `lrck` are plain levels. `busy` is a plain status output that is high while a ramp is in progress.

Top module: `soft_mute_ctrl`

## Requirements
- R1: After reset, the gain is 0 and the pass-through gate is closed (outputs zero). `out_valid` is 0, `busy` is 0 and `in_ready` is 1.
- R2: While the mute request is active, each beat accepted on the converted path (`pass_thru`=0) lowers the gain by 1. The gain saturates at 0.
- R3: While the mute request is inactive, each beat accepted on the converted path raises the gain by 1. The gain saturates at 1024. At 1024 the output equals the input.
- R4: A converted beat leaves the block as sample*g/1024, truncated toward zero. Here g is the gain held before that beat was accepted. The left and right samples of the beat use the same g.
- R5: If the request changes in the middle of a ramp, the ramp reverses from the current gain and does not restart.
- R6: The mute request is the OR of `mute` and `unlock`, so `unlock`=1 alone behaves exactly like `mute`=1.
- R7: On the pass-through path, a mute request closes the gate only at the next rising edge of `lrck`. Beats before that edge pass unchanged.
- R8: On the pass-through path, releasing the request opens the gate only at the next rising edge of `lrck`. Beats before that edge stay zero.
- R9: Beats on the pass-through path leave the gain unchanged.
- R10: `busy` is 1 exactly when the gain is strictly between 0 and 1024.
- R11: While `out_valid`=1 and `out_ready`=0, the output beat stays stable and `in_ready` is 0.
- R12: A beat accepted at a clock edge appears on the output with `out_valid`=1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mute | input | 1 | Mute request |
| unlock | input | 1 | Clock generator out of lock; acts as a mute request |
| pass_thru | input | 1 | 1 selects the pass-through path, 0 the converted path |
| lrck | input | 1 | Left/right frame clock, used on the pass-through path |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Input frame can be accepted |
| in_left | input | DATA_W | Left sample, signed |
| in_right | input | DATA_W | Right sample, signed |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Downstream accepts the output frame |
| out_left | output | DATA_W | Muted left sample, signed |
| out_right | output | DATA_W | Muted right sample, signed |
| busy | output | 1 | A gain ramp is in progress |

## Verification
A sample leaves the block one clock after it is accepted, so the bench drives each beat on a falling edge and samples the outputs on the following falling edge. It compares the output against a gain model kept in the bench, using the gain that was in effect before the update made at the acceptance edge. The new gain, and therefore `busy`, is visible at that same falling edge. A rising `lrck` changes the pass-through gate at the clock edge that samples it. For that reason the bench always lets at least one full clock pass between an `lrck` change and the next beat. Back-pressure is checked by holding `out_ready` low for several cycles and sampling the output beat and `in_ready` in each of those cycles.

// File: rtl/smute_pkg.sv
package smute_pkg;
  // Number of bits in the gain fraction; the full ramp is 2**RAMP_LOG2 frames.
  localparam int unsigned RAMP_LOG2 = 10;
  localparam int unsigned GAIN_W    = RAMP_LOG2 + 1;
  localparam int unsigned NCH       = 2;

  typedef enum logic {
    PATH_CONV = 1'b0,
    PATH_PASS = 1'b1
  } path_e;
endpackage

// File: rtl/smute_gain_ramp.sv
module smute_gain_ramp #(
  parameter int unsigned RAMP_LOG2 = 10,
  localparam int unsigned GAIN_W = RAMP_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              go_down,
  output logic [GAIN_W-1:0] gain,
  output logic              busy
);
  localparam logic [GAIN_W-1:0] FULL = GAIN_W'(1) << RAMP_LOG2;
  localparam logic [GAIN_W-1:0] ZERO = '0;

  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_d;
  logic              busy_q;

  always_comb begin
    gain_d = gain_q;
    if (step_en) begin
      if (go_down) begin
        if (gain_q != ZERO) gain_d = gain_q - GAIN_W'(1);
      end else begin
        if (gain_q != FULL) gain_d = gain_q + GAIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= ZERO;
      busy_q <= 1'b0;
    end else begin
      gain_q <= gain_d;
      busy_q <= (gain_d != ZERO) && (gain_d != FULL);
    end
  end

  assign gain = gain_q;
  assign busy = busy_q;
endmodule

// File: rtl/smute_edge_gate.sv
module smute_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  input  logic mute_req,
  output logic gate_closed
);
  logic lrck_q;
  logic closed_q;
  logic rise;

  assign rise = lrck & ~lrck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q   <= 1'b0;
      closed_q <= 1'b1;
    end else begin
      lrck_q <= lrck;
      if (rise) closed_q <= mute_req;
    end
  end

  assign gate_closed = closed_q;
endmodule

// File: rtl/smute_scaler.sv
module smute_scaler #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RAMP_LOG2 = 10,
  localparam int unsigned GAIN_W = RAMP_LOG2 + 1
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [DATA_W-1:0] scaled
);
  localparam int unsigned PW = DATA_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] BIAS = PW'((1 << RAMP_LOG2) - 1);

  logic signed [PW-1:0] s_ext;
  logic signed [PW-1:0] g_ext;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] adj;
  logic signed [PW-1:0] shifted;

  always_comb begin
    s_ext   = PW'(sample);
    g_ext   = $signed(PW'({1'b0, gain}));
    prod    = s_ext * g_ext;
    // Add the bias to a negative product so the shift truncates toward zero.
    adj     = prod[PW-1] ? (prod + BIAS) : prod;
    shifted = adj >>> RAMP_LOG2;
    scaled  = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/soft_mute_ctrl.sv
module soft_mute_ctrl #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RAMP_LOG2 = smute_pkg::RAMP_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute,
  input  logic              unlock,
  input  logic              pass_thru,
  input  logic              lrck,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              busy
);
  import smute_pkg::*;

  localparam int unsigned GW = RAMP_LOG2 + 1;

  logic              mute_req;
  logic              accept;
  path_e             path;
  logic [GW-1:0]     gain_q;
  logic              gate_closed;
  logic              out_valid_q;
  logic [DATA_W-1:0] ch_in  [NCH];
  logic [DATA_W-1:0] ch_res [NCH];
  logic [DATA_W-1:0] ch_q   [NCH];

  assign mute_req = mute | unlock;
  assign path     = path_e'(pass_thru);
  assign in_ready = ~out_valid_q | out_ready;
  assign accept   = in_valid & in_ready;

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  smute_gain_ramp #(.RAMP_LOG2(RAMP_LOG2)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (accept && (path == PATH_CONV)),
    .go_down (mute_req),
    .gain    (gain_q),
    .busy    (busy)
  );

  smute_edge_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .lrck        (lrck),
    .mute_req    (mute_req),
    .gate_closed (gate_closed)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DATA_W-1:0] scaled;

    smute_scaler #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_scale (
      .sample (ch_in[c]),
      .gain   (gain_q),
      .scaled (scaled)
    );

    always_comb begin
      if (path == PATH_PASS) ch_res[c] = gate_closed ? '0 : ch_in[c];
      else                   ch_res[c] = scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ch_q[c] <= '0;
      else if (accept) ch_q[c] <= ch_res[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid_q <= 1'b0;
    else if (accept)    out_valid_q <= 1'b1;
    else if (out_ready) out_valid_q <= 1'b0;
  end

  assign out_valid = out_valid_q;
  assign out_left  = ch_q[0];
  assign out_right = ch_q[1];
endmodule

// File: rtl/soft_mute_ctrl_chk.sv
module soft_mute_ctrl_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RAMP_LOG2 = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mute,
  input logic                 unlock,
  input logic                 pass_thru,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DATA_W-1:0]    out_left,
  input logic [DATA_W-1:0]    out_right,
  input logic [RAMP_LOG2:0]   gain_q
);
  localparam logic [RAMP_LOG2:0] FULL = (RAMP_LOG2+1)'(1) << RAMP_LOG2;

  logic acc;
  assign acc = in_valid && in_ready;

  // R11: a stalled output beat does not move
  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  // R12: an accepted beat is presented on the next cycle
  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R2 and R6: a request lowers a nonzero gain by exactly one per converted beat
  assert_ramp_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pass_thru && (mute || unlock) && gain_q != '0) |=> gain_q == $past(gain_q) - 1'b1);

  // R3: no request raises a non-full gain by exactly one per converted beat
  assert_ramp_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pass_thru && !mute && !unlock && gain_q != FULL) |=> gain_q == $past(gain_q) + 1'b1);

  // R9: the gain moves only on converted beats
  assert_gain_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && !pass_thru) |=> $stable(gain_q));

  // R4: zero gain yields silent converted output
  assert_zero_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pass_thru && gain_q == '0) |=> (out_left == '0 && out_right == '0));

  // R2/R3: the gain never exceeds unity
  always_comb begin
    if (rst_n) assert_gain_range_R3: assert (gain_q <= FULL);
  end
endmodule

bind soft_mute_ctrl soft_mute_ctrl_chk #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mute      (mute),
  .unlock    (unlock),
  .pass_thru (pass_thru),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left  (out_left),
  .out_right (out_right),
  .gain_q    (gain_q)
);

// File: tb/tb_soft_mute_ctrl.sv
module tb_soft_mute_ctrl;
  localparam int DW   = 16;
  localparam int FULL = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute = 1'b1, unlock = 1'b0, pass_thru = 1'b0, lrck = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_left = '0, in_right = '0;
  logic in_ready, out_valid, busy;
  logic [DW-1:0] out_left, out_right;

  int checks = 0;
  int errors = 0;
  int g = 0;  // model gain
  bit done = 0;

  always #2.5 clk = ~clk;

  soft_mute_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mute(mute), .unlock(unlock), .pass_thru(pass_thru),
    .lrck(lrck), .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
    .in_right(in_right), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right), .busy(busy)
  );

  // {mute, left, right} walked on the converted path right after reset
  localparam logic [32:0] VEC [10] = '{
    {1'b0, 16'sd1000,   -16'sd1000},
    {1'b0, 16'sd32767,  -16'sd32768},
    {1'b0, -16'sd5,     16'sd5},
    {1'b0, 16'sd20000,  -16'sd3},
    {1'b1, 16'sd12345,  -16'sd12345},
    {1'b1, -16'sd32768, 16'sd32767},
    {1'b1, 16'sd700,    -16'sd1},
    {1'b1, 16'sd9999,   16'sd9999},
    {1'b0, -16'sd9999,  16'sd4096},
    {1'b0, 16'sd30000,  -16'sd30000}
  };

  function automatic int scale(input logic [DW-1:0] s, input int gg);
    int sv;
    sv = int'($signed(s));
    return (sv * gg) / FULL;
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Sends one beat with out_ready high and checks it one cycle later.
  task automatic beat(input logic [DW-1:0] l, input logic [DW-1:0] r,
                      input int exp_l, input int exp_r, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(int'(out_valid), 1, {tag, " R12 out_valid"});
    check(int'($signed(out_left)), exp_l, {tag, " left"});
    check(int'($signed(out_right)), exp_r, {tag, " right"});
  endtask

  task automatic conv_beat(input logic [DW-1:0] l, input logic [DW-1:0] r, input string tag);
    beat(l, r, scale(l, g), scale(r, g), tag);
    if (mute || unlock) g = (g > 0) ? g - 1 : 0;
    else                g = (g < FULL) ? g + 1 : FULL;
    check(int'(busy), int'(g > 0 && g < FULL), {tag, " R10 busy"});
  endtask

  task automatic lrck_rise();
    @(negedge clk) lrck = 1'b1;
    @(negedge clk);
    @(negedge clk) lrck = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(int'(out_valid), 0, "R1 out_valid");
    check(int'(busy), 0, "R1 busy");
    check(int'(in_ready), 1, "R1 in_ready");

    // R1: pass-through gate closed before any lrck edge even with mute low
    mute = 1'b0; pass_thru = 1'b1;
    beat(16'sd1234, -16'sd77, 0, 0, "R1 gate closed");
    check(int'(busy), 0, "R9 busy after pass beat");

    // Vector table on the converted path (R4, R5)
    pass_thru = 1'b0;
    for (int i = 0; i < 10; i++) begin
      mute = VEC[i][32];
      conv_beat(VEC[i][31:16], VEC[i][15:0], "R4/R5 table");
    end

    // R3 ramp to unity and saturate
    mute = 1'b0;
    while (g < FULL) conv_beat(16'sd31111, -16'sd31111, "R3 ramp up");
    conv_beat(16'sd31111, -16'sd31111, "R3 saturated");
    check(int'($signed(out_left)), 31111, "R3 unity output");

    // R5 reversal mid-ramp
    mute = 1'b1;
    for (int i = 0; i < 5; i++) conv_beat(16'sd20001, -16'sd20001, "R5 down");
    mute = 1'b0;
    for (int i = 0; i < 5; i++) conv_beat(16'sd20001, -16'sd20001, "R5 reverse up");
    check(g, FULL, "R5 model back at unity");
    check(int'(busy), 0, "R5 busy at unity");

    // Pass-through gating (R7, R8) with gain held at unity (R9)
    pass_thru = 1'b1;
    lrck_rise();
    beat(16'sd500, -16'sd600, 500, -600, "R8 open after edge");
    mute = 1'b1;
    beat(16'sd501, -16'sd601, 501, -601, "R7 mute before edge");
    lrck_rise();
    beat(16'sd502, -16'sd602, 0, 0, "R7 closed after edge");
    mute = 1'b0;
    beat(16'sd503, -16'sd603, 0, 0, "R8 release before edge");
    lrck_rise();
    beat(16'sd504, -16'sd604, 504, -604, "R8 open after edge");

    // R11 back-pressure on the pass path
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_left = 16'sd111; in_right = 16'sd222;
    @(posedge clk);
    @(negedge clk);
    in_left = 16'sd333; in_right = 16'sd444;
    for (int k = 0; k < 3; k++) begin
      check(int'(in_ready), 0, "R11 in_ready stalled");
      check(int'($signed(out_left)), 111, "R11 held left");
      check(int'($signed(out_right)), 222, "R11 held right");
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(int'($signed(out_left)), 333, "R11 next beat left");
    @(negedge clk);
    check(int'(out_valid), 0, "R11 drained");

    // R9: gain still unity after pass-through beats
    pass_thru = 1'b0;
    conv_beat(-16'sd7777, 16'sd7777, "R9 gain kept");
    check(int'($signed(out_left)), -7777, "R9 unity after pass");

    // R6 unlock acts as mute; R2 full ramp down with saturation
    unlock = 1'b1;
    conv_beat(16'sd8191, -16'sd8191, "R6 unlock first step");
    check(g, FULL - 1, "R6 model stepped down");
    while (g > 0) conv_beat(-16'sd32768, 16'sd32767, "R2 ramp down");
    conv_beat(-16'sd32768, 16'sd32767, "R2 saturated");
    check(int'(out_left), 0, "R2 silent");
    check(int'(busy), 0, "R2 busy idle");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule